// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is the serial configuration port of a clock generator. It listens on a two-wire SMBus/I2C bus and holds 21 byte-wide configuration registers, numbered 0 to 20. It exports their contents as one parallel vector to the frequency, skew and watchdog logic. The bus lines are sampled in the system clock domain through a two-flop synchronizer. START and STOP are recognised as SDA edges while SCL is high, and the slave pulls SDA low to acknowledge or to send read data.

Writes use only the block-write form. The master sends the device address, a command byte and a count byte, and the slave acknowledges both of these bytes and then throws them away. Every data byte after them lands in the next register, beginning at register 0 on every transaction, until the master sends a STOP. Two register pairs, 11/12 and 13/14, hold divider and spread settings that must never be half updated. The first byte of each pair is held in a staging buffer and is copied into the pair only when the second byte arrives in the same transaction. A read returns registers from 0 upward, and register 8 sets how many real bytes come back.

Top module: `cfgbus_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal the device address (default 7'h69), by pulling SDA low during the ninth clock. Bit 0 selects a write (0) or a read (1). Any other address gets no acknowledge and leaves every register unchanged.
- R2: In a write, the first two bytes after the address (command and count) are acknowledged and discarded. Data byte k, counting from 0, is stored in register k. Every data byte is acknowledged, and bytes for registers above 20 are dropped.
- R3: A STOP after any complete byte leaves the registers already written with their new values and all later registers unchanged.
- R4: Registers 11 and 12 change only when both bytes arrive in one transaction, and then they change together. Registers 13 and 14 follow the same rule. If only the lower byte of a pair arrives, neither register of that pair changes.
- R5: Register 8 (read length) resets to 08h. A write of 00h to it is ignored and its previous value is kept.
- R6: After reset, register 9 holds 10h and register 7 holds {4'b1001, revision} (revision default 4'h3). All other registers hold 00h. Register 7 ignores writes.
- R7: In a read, the slave sends register i as the i-th byte, MSB first, starting at 0. It sends real data only for bytes where i is below the value in register 8 and i ≤ 20, and sends FFh for every other byte. After a master NACK the slave stops driving.
- R8: A repeated START begins a new transaction at register 0 and clears the pair staging.
- R9: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND) |
| sda_pull_low | output | 1 | 1 = pull the data line low |
| cfg_regs | output | 168 | Register contents; register r sits at bits [8r+7:8r] |

## Verification
The events that sit closest together are the staging of a pair's lower byte and the clearing of that staging by a new START. In the same area, the commit of the upper byte and a STOP can fall in the same byte time. The bench provokes the first case by ending a write right after register 11, and then after register 12. It provokes a restart by sending a repeated START in the middle of a write. A behavioural model of staging and commit is compared with the exported registers on every clock between transactions, so a pair that moves alone or too early is caught. Reads are judged against the model for the length set in register 8, with FFh expected past that length.

// File: rtl/cfgbus_pkg.sv
// Package: register map constants, bus FSM states and reset values shared
// by the configuration slave. Assumes a fixed 21-register map.
package cfgbus_pkg;
    localparam int NUM_REGS   = 21;
    localparam int REG_ID     = 7;
    localparam int REG_RDLEN  = 8;
    localparam int REG_WDOG   = 9;
    localparam int NUM_PAIRS  = 2;
    localparam int PAIR_FIRST = 11;
    localparam int HDR_BYTES  = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_WAIT
    } bus_st_t;

    function automatic logic [7:0] reg_reset(input int idx, input logic [3:0] rev);
        case (idx)
            REG_ID:    return {4'b1001, rev};
            REG_RDLEN: return 8'h08;
            REG_WDOG:  return 8'h10;
            default:   return 8'h00;
        endcase
    endfunction

    // True for registers written directly by a data byte.
    function automatic bit reg_is_plain(input int idx);
        if (idx == REG_ID || idx == REG_RDLEN) return 1'b0;
        if (idx >= PAIR_FIRST && idx < PAIR_FIRST + 2 * NUM_PAIRS) return 1'b0;
        return 1'b1;
    endfunction
endpackage

// File: rtl/cfgbus_line_sync.sv
// Line synchronizer: brings SCL/SDA into the clk domain through STAGES flops
// and flags SCL edges plus START/STOP. Assumes bus phases last several clocks.
module cfgbus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_p;
    logic [STAGES:0] sda_p;
    logic scl_prev, sda_prev;

    // Shift both lines through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_pin};
            sda_p <= {sda_p[STAGES-1:0], sda_pin};
        end
    end

    assign scl_lvl   = scl_p[STAGES-1];
    assign sda_lvl   = sda_p[STAGES-1];
    assign scl_prev  = scl_p[STAGES];
    assign sda_prev  = sda_p[STAGES];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/cfgbus_bit_engine.sv
// Bit engine: address match, byte shifting, acknowledge and read transmit.
// Emits one pulse per received write byte. Assumes synchronized inputs and
// changes the SDA drive only on detected SCL falls.
module cfgbus_bit_engine
    import cfgbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_byte,
    output logic [7:0] rd_idx,
    output logic       sda_low,
    output logic       start_p,
    output logic       byte_p,
    output logic [7:0] byte_d
);
    bus_st_t    st;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic       rw;
    logic       nack;

    assign start_p = start_det;

    // Bus protocol state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '0;
            rw      <= 1'b0;
            nack    <= 1'b0;
            rd_idx  <= '0;
            sda_low <= 1'b0;
            byte_p  <= 1'b0;
            byte_d  <= '0;
        end else begin
            byte_p <= 1'b0;
            if (start_det) begin
                st      <= ST_ADDR;
                bit_cnt <= '0;
                sda_low <= 1'b0;
            end else if (stop_det) begin
                st      <= ST_IDLE;
                sda_low <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (st == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    st      <= ST_ADDR_ACK;
                                    sda_low <= 1'b1;
                                    rw      <= shreg[0];
                                    rd_idx  <= '0;
                                end else begin
                                    st <= ST_WAIT;
                                end
                            end else begin
                                byte_p  <= 1'b1;
                                byte_d  <= shreg;
                                sda_low <= 1'b1;
                                st      <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw) begin
                                tx      <= rd_byte;
                                sda_low <= ~rd_byte[7];
                                st      <= ST_RD;
                            end else begin
                                sda_low <= 1'b0;
                                st      <= ST_WR;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_low <= 1'b0;
                            bit_cnt <= '0;
                            st      <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_low <= 1'b0;
                                st      <= ST_RD_ACK;
                                if (rd_idx != 8'hFF) rd_idx <= rd_idx + 8'd1;
                            end else begin
                                tx      <= {tx[6:0], 1'b0};
                                sda_low <= ~tx[6];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            nack <= sda_lvl;
                        end else if (scl_fall) begin
                            if (nack) begin
                                st <= ST_WAIT;
                            end else begin
                                tx      <= rd_byte;
                                sda_low <= ~rd_byte[7];
                                bit_cnt <= '0;
                                st      <= ST_RD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_low) || $fell(sda_low)) |-> !scl_lvl);

    assert_release_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_low);

    assert_data_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_p |-> sda_low);
endmodule

// File: rtl/cfgbus_regbank.sv
// Register bank: maps received data bytes onto registers 0..NREG-1, stages
// the lower byte of each atomic pair, and muxes read data. Assumes byte_p
// pulses include the two discarded header bytes.
module cfgbus_regbank
    import cfgbus_pkg::*;
#(
    parameter int         NREG = NUM_REGS,
    parameter logic [3:0] REV  = 4'h3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_p,
    input  logic                 byte_p,
    input  logic [7:0]           byte_d,
    input  logic [7:0]           rd_idx,
    output logic [7:0]           rd_byte,
    output logic [NREG-1:0][7:0] regs
);
    localparam int AW = $clog2(NREG);

    logic [7:0]           byte_num;
    logic [7:0]           didx;
    logic                 data_ok;
    logic [NUM_PAIRS-1:0] commit;
    logic [7:0]           stg_val [NUM_PAIRS];
    logic [NREG-1:0][7:0] nxt;

    assign didx    = byte_num - 8'(HDR_BYTES);
    assign data_ok = byte_p && (byte_num >= 8'(HDR_BYTES));

    // Count bytes of the current transaction, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                          byte_num <= '0;
        else if (start_p)                    byte_num <= '0;
        else if (byte_p && byte_num != 8'hFF) byte_num <= byte_num + 8'd1;
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int LO = PAIR_FIRST + 2 * p;
        logic [7:0] stg;
        logic       stg_v;

        // Hold the lower byte of this pair until its partner arrives.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg   <= '0;
                stg_v <= 1'b0;
            end else if (start_p) begin
                stg_v <= 1'b0;
            end else if (data_ok && didx == 8'(LO)) begin
                stg   <= byte_d;
                stg_v <= 1'b1;
            end
        end

        assign commit[p]  = data_ok && didx == 8'(LO + 1) && stg_v;
        assign stg_val[p] = stg;

        assert_pair_atomic_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (regs[LO] != $past(regs[LO])) |-> (regs[LO+1] == $past(byte_d) && $past(byte_p)));
    end

    // Next register values from plain writes, length writes and pair commits.
    always_comb begin
        nxt = regs;
        for (int r = 0; r < NREG; r++) begin
            if (reg_is_plain(r) && data_ok && didx == 8'(r)) nxt[r] = byte_d;
        end
        if (data_ok && didx == 8'(REG_RDLEN) && byte_d != 8'h00) nxt[REG_RDLEN] = byte_d;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (commit[p]) begin
                nxt[PAIR_FIRST + 2 * p]     = stg_val[p];
                nxt[PAIR_FIRST + 2 * p + 1] = byte_d;
            end
        end
    end

    // Register storage with defined reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) regs[r] <= reg_reset(r, REV);
        end else begin
            regs <= nxt;
        end
    end

    // Read data: real registers inside the programmed length, FFh beyond.
    always_comb begin
        rd_byte = 8'hFF;
        if (rd_idx < regs[REG_RDLEN] && rd_idx < 8'(NREG)) rd_byte = regs[rd_idx[AW-1:0]];
    end

    assert_rdlen_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        regs[REG_RDLEN] != 8'h00);

    assert_id_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(regs[REG_ID]));
endmodule

// File: rtl/cfgbus_slave.sv
// Top: block-write configuration slave. Synchronizes the bus, runs the bit
// engine and exports the register bank as a flat vector. Assumes SDA is an
// external wired-AND line with the pull-low output driving its pad.
module cfgbus_slave
    import cfgbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [3:0] REV         = 4'h3,
    parameter int         SYNC_STAGES = 2,
    parameter int         NREG        = NUM_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    output logic [NREG*8-1:0] cfg_regs
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic start_p, byte_p;
    logic [7:0] byte_d, rd_idx, rd_byte;
    logic [NREG-1:0][7:0] regs;

    cfgbus_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_pin(scl_in), .sda_pin(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    cfgbus_bit_engine #(.DEV_ADDR(DEV_ADDR)) eng_i (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_byte(rd_byte), .rd_idx(rd_idx),
        .sda_low(sda_pull_low), .start_p(start_p), .byte_p(byte_p), .byte_d(byte_d)
    );

    cfgbus_regbank #(.NREG(NREG), .REV(REV)) bank_i (
        .clk(clk), .rst_n(rst_n), .start_p(start_p), .byte_p(byte_p),
        .byte_d(byte_d), .rd_idx(rd_idx), .rd_byte(rd_byte), .regs(regs)
    );

    assign cfg_regs = regs;
endmodule

// File: tb/cfgbus_slave_tb_top.sv
module cfgbus_slave_tb_top;
    localparam int         NREG = 21;
    localparam logic [6:0] ADDR = 7'h69;
    localparam logic [3:0] REV  = 4'h3;
    localparam int         Q    = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_low;
    logic sda_line;
    logic [NREG*8-1:0] cfg_regs;

    assign sda_line = sda_m & ~sda_low;

    cfgbus_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull_low(sda_low), .cfg_regs(cfg_regs)
    );

    int checks = 0;
    int errors = 0;
    int r9_viol = 0;
    bit cmp_en = 0;
    logic [7:0] model [NREG];
    logic [7:0] stg [2];
    bit stg_v [2];
    logic prev_low = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int r = 0; r < NREG; r++) model[r] = 8'h00;
        model[7] = {4'b1001, REV};
        model[8] = 8'h08;
        model[9] = 8'h10;
        stg_v[0] = 0;
        stg_v[1] = 0;
    endfunction

    // Behavioural model of one stored data byte (R2, R4, R5, R6).
    function automatic void model_byte(input int k, input logic [7:0] v);
        int p;
        if (k >= NREG || k == 7) return;
        if (k == 8) begin
            if (v != 8'h00) model[8] = v;
            return;
        end
        if (k == 11 || k == 13) begin
            p = (k - 11) / 2;
            stg[p] = v;
            stg_v[p] = 1;
            return;
        end
        if (k == 12 || k == 14) begin
            p = (k - 12) / 2;
            if (stg_v[p]) begin
                model[k-1] = stg[p];
                model[k] = v;
            end
            return;
        end
        model[k] = v;
    endfunction

    // Register image compared with the model on every clock between transactions.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                checks++;
                if (cfg_regs[r*8 +: 8] !== model[r]) begin
                    errors++;
                    $display("FAIL R2 reg %0d act=%0h exp=%0h", r, cfg_regs[r*8 +: 8], model[r]);
                end
            end
        end
    end

    // R9: the slave drive may only change while SCL is low.
    always @(negedge clk) begin
        if (rst_n && sda_low !== prev_low && scl_m) r9_viol++;
        prev_low = sda_low;
    end

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        stg_v[0] = 0;
        stg_v[1] = 0;
        sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
    endtask

    task automatic bus_stop();
        sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q();
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q(); scl_m = 1; q(); q(); scl_m = 0; q();
        end
        sda_m = 1; q(); scl_m = 1; q();
        acked = !sda_line;
        q(); scl_m = 0; q();
    endtask

    task automatic get_byte(output logic [7:0] b, input bit master_ack);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            q(); scl_m = 1; q(); b[i] = sda_line; q(); scl_m = 0;
        end
        q(); sda_m = master_ack ? 1'b0 : 1'b1; q(); scl_m = 1; q(); q(); scl_m = 0; q(); sda_m = 1;
    endtask

    task automatic write_txn(input logic [6:0] a, input logic [7:0] data[$],
                             input bit do_stop, input bit exp_ack, input string req);
        bit ack;
        cmp_en = 0;
        bus_start();
        put_byte({a, 1'b0}, ack);
        chk(req, 32'(ack), 32'(exp_ack), "address ack");
        if (ack) begin
            put_byte(8'hC3, ack);
            chk("R2", 32'(ack), 32'd1, "command byte ack");
            put_byte(8'h5A, ack);
            chk("R2", 32'(ack), 32'd1, "count byte ack");
            foreach (data[k]) begin
                put_byte(data[k], ack);
                chk("R2", 32'(ack), 32'd1, "data byte ack");
                model_byte(k, data[k]);
            end
        end
        if (do_stop) begin
            bus_stop();
            repeat (8) @(negedge clk);
            cmp_en = 1;
        end
    endtask

    task automatic read_txn(input int n);
        bit ack;
        logic [7:0] b;
        logic [7:0] e;
        cmp_en = 0;
        bus_start();
        put_byte({ADDR, 1'b1}, ack);
        chk("R1", 32'(ack), 32'd1, "read address ack");
        for (int i = 0; i < n; i++) begin
            get_byte(b, i < n - 1);
            e = (i < int'(model[8]) && i < NREG) ? model[i] : 8'hFF;
            chk("R7", 32'(b), 32'(e), $sformatf("read byte %0d", i));
        end
        bus_stop();
        repeat (8) @(negedge clk);
        chk("R7", 32'(sda_low), 32'd0, "released after NACK");
        cmp_en = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d[$];
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_en = 1;
        chk("R6", 32'(cfg_regs[7*8 +: 8]), {24'd0, 4'b1001, REV}, "id reset");
        chk("R5", 32'(cfg_regs[8*8 +: 8]), 32'h08, "length reset");
        chk("R6", 32'(cfg_regs[9*8 +: 8]), 32'h10, "watchdog reset");
        chk("R1", 32'(sda_low), 32'd0, "idle drive");

        // R1: foreign address is ignored.
        d = '{8'h11, 8'h22};
        write_txn(7'h22, d, 1, 0, "R1");
        chk("R1", 32'(cfg_regs[0 +: 8]), 32'h00, "reg0 after foreign address");

        // R2/R6: full write past the last register.
        d.delete();
        for (int k = 0; k < 25; k++) d.push_back(k == 8 ? 8'h0C : 8'(8'h40 + k));
        write_txn(ADDR, d, 1, 1, "R1");
        chk("R6", 32'(cfg_regs[7*8 +: 8]), {24'd0, 4'b1001, REV}, "id not writable");
        chk("R4", 32'(cfg_regs[12*8 +: 8]), 32'h4C, "pair A full write");

        // R3/R4/R5: stop after register 11; pair A stays, length 00h ignored.
        d.delete();
        for (int k = 0; k < 12; k++) d.push_back(k == 8 ? 8'h00 : 8'(8'h90 + k));
        write_txn(ADDR, d, 1, 1, "R1");
        chk("R3", 32'(cfg_regs[10*8 +: 8]), 32'h9A, "reg10 before stop");
        chk("R4", 32'(cfg_regs[11*8 +: 8]), 32'h4B, "lone lower byte");
        chk("R5", 32'(cfg_regs[8*8 +: 8]), 32'h0C, "zero length ignored");

        // R4: stop after register 12 commits pair A only.
        d.delete();
        for (int k = 0; k < 13; k++) d.push_back(8'(8'hE0 + k));
        write_txn(ADDR, d, 1, 1, "R1");
        chk("R4", 32'(cfg_regs[11*8 +: 8]), 32'hEB, "pair A low committed");
        chk("R4", 32'(cfg_regs[12*8 +: 8]), 32'hEC, "pair A high committed");
        chk("R4", 32'(cfg_regs[13*8 +: 8]), 32'h4D, "pair B untouched");

        // R8: repeated START restarts at register 0.
        d = '{8'h01, 8'h02, 8'h03, 8'h04};
        write_txn(ADDR, d, 0, 1, "R1");
        d = '{8'hF0, 8'hF1};
        write_txn(ADDR, d, 1, 1, "R1");
        chk("R8", 32'(cfg_regs[0 +: 8]), 32'hF0, "restart reg0");
        chk("R8", 32'(cfg_regs[2*8 +: 8]), 32'h03, "restart reg2 kept");

        // R7: long length then short length.
        read_txn(23);
        d.delete();
        for (int k = 0; k < 9; k++) d.push_back(k == 8 ? 8'h03 : 8'(8'h20 + k));
        write_txn(ADDR, d, 1, 1, "R1");
        read_txn(5);

        chk("R9", 32'(r9_viol), 32'd0, "drive changes while SCL high");
        cmp_en = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule